// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration-space target of a legacy I/O controller. It sits on a byte-wide I/O bus and answers at two addresses: an index port at the base address and a data port at the next address. After reset the target is locked. In this state reads of the data port return all ones and writes to it have no effect. An unlock sequence writes the enter key (0x87) to the index port twice in a row. After that, index-port writes choose a register, and data-port accesses read or write the chosen register. Writing the exit key (0xAA) to the index port locks the target again.

Offsets below 0x30 are global. Offset 0x07 holds the logical device number. Offsets 0x20 and 0x21 return a fixed identification word: a 12-bit chip code followed by a 4-bit revision. Offsets from 0x30 upward are banked: they reach the bank whose logical device number is currently selected. Each bank has a function-enable register at 0x30, and its contents drive the enable outputs used by the peripheral logic. The base address is chosen at run time by a strap input, which selects one of two parameterised bases.

The unlock logic is a state machine with three states:
- LOCKED moves to KEY1 on an index write of 0x87.
- KEY1 moves to OPEN on a second index write of 0x87.
- KEY1 falls back to LOCKED on an index write of any other value.
- OPEN returns to LOCKED on an index write of 0xAA.
- All other cycles hold the current state.

Top module: `sio_cfg_port`

## Requirements
- R1: The index port is at address 0x2E when `base_sel` is 0 and at 0x4E when it is 1. The data port is at the index address plus one. Accesses to any other address read 0xFF and change nothing.
- R2: After reset the port is locked, and every bank enable output is 0. While the port is not open, index-port and data-port reads return 0xFF and data-port writes change no register.
- R3: Two consecutive index-port writes of 0x87 open the port.
- R4: An index-port write of any value other than 0x87 between the two keys restarts the unlock sequence. Data-port writes between the keys do not break the sequence.
- R5: An index-port write of 0xAA while open locks the port. The index register keeps its value across the lock.
- R6: While open, an index-port write of any value other than 0xAA loads the index register. An index-port read returns that value.
- R7: Global offset 0x07 is the logical device number register. It is readable and writable and resets to 0x00.
- R8: Offset 0x20 reads the upper 8 bits of the 12-bit chip code (default 0xA2). Offset 0x21 reads the low 4 bits of the code followed by the revision (default 0x35). Writes to both offsets are ignored.
- R9: Offsets 0x30 and up reach the bank selected by offset 0x07. Banks exist for device numbers 0x07, 0x08 and 0x09. The enable register of bank k sits at offset 0x30, reads back, and drives `dev_enable[8k+7:8k]`.
- R10: When the selected device number has no bank, offsets 0x30 and up read 0x00 and writes to them change no enable output.
- R11: Unimplemented global offsets, and unimplemented offsets inside a bank, read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_sel | input | 1 | Base select strap: 0 selects the low base, 1 selects the high base |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, a combinational function of the address and state |
| dev_enable | output | 24 | Enable registers of the three banks, bank 0 in the low byte |

## Verification
The bench covers the following corner cases:
- **Unlock sequence broken by a stray index write.** A design that only counted keys would open anyway. The bench checks that the data port still reads 0xFF in this case.
- **Data-port write between the two keys.** A design that reset the sequence on any bus write would stay locked. The bench checks that the port opens.
- **Index register across a lock.** A design that cleared the index on exit would read back a wrong index after the next unlock. The bench checks that the index survives.
- **Device number with no bank.** An incomplete bank decoder could let a write land in a real bank. The bench checks that every enable output stays unchanged.
- **Unselected base address.** A design that ignored the strap would respond at the wrong address. The bench checks that the unselected base stays silent.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_KEY1   = 2'd1,
        ST_OPEN   = 2'd2
    } cfg_state_e;

    localparam logic [7:0] KEY_ENTER  = 8'h87;
    localparam logic [7:0] KEY_EXIT   = 8'hAA;
    localparam logic [7:0] REG_LDN    = 8'h07;
    localparam logic [7:0] REG_ID_HI  = 8'h20;
    localparam logic [7:0] REG_ID_LO  = 8'h21;
    localparam logic [7:0] BANK_START = 8'h30;
    localparam logic [7:0] REG_ENABLE = 8'h30;
endpackage

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output cfg_state_e st,
    output logic       cfg_open
);
    cfg_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LOCKED;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_LOCKED: if (idx_wr && wdata == KEY_ENTER) nxt = ST_KEY1;
            ST_KEY1:   if (idx_wr) nxt = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
            ST_OPEN:   if (idx_wr && wdata == KEY_EXIT) nxt = ST_LOCKED;
            default:   nxt = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        cfg_open = (st == ST_OPEN);
    end
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
    import sio_cfg_pkg::*;
#(
    parameter int         EN_W   = 8,
    parameter logic [7:0] MY_LDN = 8'h07
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      ldn,
    input  logic [7:0]      index,
    input  logic [7:0]      wdata,
    input  logic            dat_wr,
    output logic [EN_W-1:0] enable,
    output logic [7:0]      rdata
);
    logic at_en;

    assign at_en = (ldn == MY_LDN) && (index == REG_ENABLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                enable <= '0;
        else if (dat_wr && at_en)  enable <= wdata[EN_W-1:0];
    end

    always_comb begin
        rdata = 8'h00;
        if (at_en) rdata = 8'(enable);
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_LO   = 16'h002E,
    parameter logic [15:0] BASE_HI   = 16'h004E,
    parameter logic [11:0] CHIP_CODE = 12'hA23,
    parameter logic [3:0]  CHIP_REV  = 4'h5,
    parameter int          NUM_BANKS = 3,
    parameter logic [7:0]  FIRST_LDN = 8'h07,
    parameter int          EN_W      = 8,
    localparam int         OUT_W     = NUM_BANKS * EN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [OUT_W-1:0]  dev_enable
);
    localparam logic [7:0] ID_HI = CHIP_CODE[11:4];
    localparam logic [7:0] ID_LO = {CHIP_CODE[3:0], CHIP_REV};

    cfg_state_e        st;
    logic              cfg_open;
    logic [ADDR_W-1:0] base_addr;
    logic              idx_hit, dat_hit, idx_wr, dat_wr;
    logic [7:0]        index_q, ldn_q;
    logic [7:0]        bank_rd [NUM_BANKS];
    logic [7:0]        bank_or;

    assign base_addr = base_sel ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
    assign idx_hit   = (io_addr == base_addr);
    assign dat_hit   = (io_addr == base_addr + ADDR_W'(1));
    assign idx_wr    = io_wr && idx_hit;
    assign dat_wr    = io_wr && dat_hit && cfg_open;

    sio_cfg_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (io_wdata),
        .st       (st),
        .cfg_open (cfg_open)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            ldn_q   <= 8'h00;
        end else begin
            if (idx_wr && cfg_open && io_wdata != KEY_EXIT) index_q <= io_wdata;
            if (dat_wr && index_q == REG_LDN)               ldn_q   <= io_wdata;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sio_cfg_bank #(
            .EN_W   (EN_W),
            .MY_LDN (FIRST_LDN + 8'(g))
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .ldn    (ldn_q),
            .index  (index_q),
            .wdata  (io_wdata),
            .dat_wr (dat_wr),
            .enable (dev_enable[g*EN_W +: EN_W]),
            .rdata  (bank_rd[g])
        );
    end

    always_comb begin
        bank_or = 8'h00;
        for (int k = 0; k < NUM_BANKS; k++) bank_or = bank_or | bank_rd[k];
    end

    always_comb begin
        io_rdata = 8'hFF;
        if (idx_hit) begin
            io_rdata = cfg_open ? index_q : 8'hFF;
        end else if (dat_hit && cfg_open) begin
            if (index_q >= BANK_START) begin
                io_rdata = bank_or;
            end else begin
                unique case (index_q)
                    REG_LDN:   io_rdata = ldn_q;
                    REG_ID_HI: io_rdata = ID_HI;
                    REG_ID_LO: io_rdata = ID_LO;
                    default:   io_rdata = 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
#(
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idx_wr,
    input logic             dat_hit,
    input logic [7:0]       wdata,
    input cfg_state_e       st,
    input logic [7:0]       index,
    input logic [7:0]       rdata,
    input logic [OUT_W-1:0] dev_enable
);
    assert_locked_reads_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OPEN && dat_hit) |-> rdata == 8'hFF);

    assert_locked_enables_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OPEN) |=> $stable(dev_enable));

    assert_second_key_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KEY1 && idx_wr && wdata == KEY_ENTER) |=> st == ST_OPEN);

    assert_stray_write_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KEY1 && idx_wr && wdata != KEY_ENTER) |=> st == ST_LOCKED);

    assert_exit_key_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPEN && idx_wr && wdata == KEY_EXIT) |=> st == ST_LOCKED);

    assert_index_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPEN && idx_wr && wdata != KEY_EXIT) |=> index == $past(wdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (idx_wr),
    .dat_hit    (dat_hit),
    .wdata      (io_wdata),
    .st         (st),
    .index      (index_q),
    .rdata      (io_rdata),
    .dev_enable (dev_enable)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_sel;
    logic [15:0] io_addr;
    logic        io_wr;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic [23:0] dev_enable;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_cfg_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_sel   (base_sel),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .dev_enable (dev_enable)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b0; io_addr = a;
        #1 d = io_rdata;
    endtask

    task automatic unlock();
        wr(IDX, 8'h87); wr(IDX, 8'h87);
    endtask

    task automatic set_reg(input logic [7:0] r, input logic [7:0] v);
        wr(IDX, r); wr(DAT, v);
    endtask

    task automatic get_reg(input logic [7:0] r, output logic [7:0] v);
        wr(IDX, r); rd(DAT, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(DAT, v);   check("R2 data read after reset", v, 8'hFF);
        rd(IDX, v);   check("R2 index read after reset", v, 8'hFF);
        check("R2 enables after reset", dev_enable, 24'h0);
    endtask

    task automatic t_locked_ignores();
        logic [7:0] v;
        unlock();
        wr(IDX, 8'h07);
        wr(IDX, 8'hAA);
        wr(DAT, 8'h08);
        rd(DAT, v);   check("R5 data read after exit", v, 8'hFF);
        unlock();
        rd(IDX, v);   check("R5 index kept across lock", v, 8'h07);
        rd(DAT, v);   check("R2 locked write ignored (R7 ldn)", v, 8'h00);
    endtask

    task automatic t_chip_id();
        logic [7:0] v;
        get_reg(8'h20, v); check("R8 id high", v, 8'hA2);
        wr(DAT, 8'h00);
        rd(DAT, v);        check("R8 id high write ignored", v, 8'hA2);
        get_reg(8'h21, v); check("R8 id low", v, 8'h35);
        rd(IDX, v);        check("R6 index readback", v, 8'h21);
        wr(IDX, 8'h87);
        rd(IDX, v);        check("R6 enter key as index while open", v, 8'h87);
        wr(IDX, 8'h21);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        wr(IDX, 8'hAA);
        wr(IDX, 8'h87); wr(IDX, 8'h55); wr(IDX, 8'h87);
        rd(DAT, v);   check("R4 stray write restarts", v, 8'hFF);
        wr(IDX, 8'h87);
        rd(DAT, v);   check("R3 keys after restart open (id low)", v, 8'h35);
        wr(IDX, 8'hAA);
        wr(IDX, 8'h87); wr(DAT, 8'h12); wr(IDX, 8'h87);
        rd(DAT, v);   check("R4 data write between keys harmless", v, 8'h35);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        set_reg(8'h07, 8'h08);
        rd(DAT, v);        check("R7 ldn readback", v, 8'h08);
        set_reg(8'h30, 8'h5A);
        check("R9 bank 1 enable output", dev_enable, 24'h005A00);
        set_reg(8'h07, 8'h07);
        set_reg(8'h30, 8'hC3);
        check("R9 bank 0 enable output", dev_enable, 24'h005AC3);
        rd(DAT, v);        check("R9 bank 0 readback", v, 8'hC3);
        set_reg(8'h07, 8'h08);
        get_reg(8'h30, v); check("R9 bank 1 readback", v, 8'h5A);
        set_reg(8'h07, 8'h09);
        set_reg(8'h30, 8'h0F);
        check("R9 bank 2 enable output", dev_enable, 24'h0F5AC3);
        get_reg(8'h31, v); check("R11 bank offset 0x31", v, 8'h00);
        get_reg(8'h10, v); check("R11 global offset 0x10", v, 8'h00);
    endtask

    task automatic t_no_bank();
        logic [7:0] v;
        set_reg(8'h07, 8'h0D);
        set_reg(8'h30, 8'hFF);
        check("R10 missing bank write ignored", dev_enable, 24'h0F5AC3);
        rd(DAT, v);        check("R10 missing bank reads zero", v, 8'h00);
    endtask

    task automatic t_exit();
        logic [7:0] v;
        set_reg(8'h07, 8'h07);
        wr(IDX, 8'h30);
        wr(IDX, 8'hAA);
        wr(DAT, 8'h00);
        rd(DAT, v);   check("R5 locked after exit", v, 8'hFF);
        check("R5 locked write leaves enables", dev_enable, 24'h0F5AC3);
    endtask

    task automatic t_base();
        logic [7:0] v;
        base_sel = 1'b1;
        wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
        wr(16'h004E, 8'h20);
        rd(16'h004F, v);     check("R1 high base data port", v, 8'hA2);
        rd(16'h002F, v);     check("R1 low base silent", v, 8'hFF);
        wr(16'h002E, 8'hAA);
        rd(16'h004F, v);     check("R1 exit at wrong base ignored", v, 8'hA2);
        rd(16'h0050, v);     check("R1 other address", v, 8'hFF);
        wr(16'h004E, 8'hAA);
        rd(16'h004F, v);     check("R1 exit at high base", v, 8'hFF);
        base_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; base_sel = 1'b0; io_addr = '0; io_wr = 1'b0; io_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked_ignores();
        t_chip_id();
        t_restart();
        t_banks();
        t_no_bank();
        t_exit();
        t_base();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule